// File: doc/BRIEF.md
# Scalar AES Byte Round-Step Unit

This unit carries out one byte-wide step of an AES round for a 32-bit processor datapath. Each operation takes two 32-bit operands, a 2-bit byte index and a 2-bit operation code. The byte of the second operand named by the index goes through the forward or the inverse substitution box. Final-round operations use the substituted byte alone. Middle-round operations expand it into one column of the forward or inverse MixColumns product. The resulting word is rotated left by whole bytes according to the index and XORed into the first operand.

Four operations issued with indices 0 to 3 on the same accumulator build a full column of a round output. Both substitution paths and both column expansions are evaluated on every operation, and the result register captures the selected path one clock after issue. Timing therefore never depends on operand values or on the operation chosen.

Top module: `aes_byte_step`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R2: `bsel` picks the byte `op_b[8*bsel+7 : 8*bsel]`; the other three bytes of `op_b` have no effect on `result`.
- R3: Opcode 2'b00 (encrypt, final round): the forward S-box output of the selected byte, zero-extended to 32 bits, forms the word.
- R4: Opcode 2'b01 (encrypt, middle round): with s the forward S-box output, the word is {3·s, s, s, 2·s} from most to least significant byte, products in GF(2^8) modulo 0x11B.
- R5: Opcode 2'b10 (decrypt, final round): the inverse S-box output of the selected byte, zero-extended to 32 bits, forms the word.
- R6: Opcode 2'b11 (decrypt, middle round): with t the inverse S-box output, the word is {0x0B·t, 0x0D·t, 0x09·t, 0x0E·t} from most to least significant byte.
- R7: The word is rotated left by 8·bsel bits, then XORed with `op_a` to form `result`.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, for every operand value and opcode; no other latency exists.
- R9: In a cycle after one with `in_valid` low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| opcode | input | 2 | Bit 1: decrypt; bit 0: middle round |
| bsel | input | 2 | Byte index into `op_b` and rotation amount |
| op_a | input | 32 | Accumulator operand XORed into the result |
| op_b | input | 32 | Operand that supplies the substituted byte |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 32 | Result word |

## Verification
Every result is due one rising edge after its issue: inputs are applied at a falling edge, the register captures them at the next rising edge, and the bench compares at the falling edge after that. The bench never samples on a rising edge. Back-to-back issue checks each result at the falling edge where the next operation is applied, which shows that the latency is one cycle for any operation mix. The hold test checks at each falling edge over several idle cycles that `result` stays at its last value while the inputs change.

// File: rtl/aes_step_pkg.sv
package aes_step_pkg;

   typedef enum logic [1:0] {
      OP_ENC_LAST = 2'b00,
      OP_ENC_MID  = 2'b01,
      OP_DEC_LAST = 2'b10,
      OP_DEC_MID  = 2'b11
   } aes_op_e;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_xt(input logic [7:0] v);
      return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] pw;
      acc = 8'h00;
      pw  = a;
      for (int k = 0; k < 8; k++) begin
         if (b[k]) acc = acc ^ pw;
         pw = gf_xt(pw);
      end
      return acc;
   endfunction

   // multiplicative inverse as a^254 (0 maps to 0)
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] p2, p3, p12, p15, p240, p252;
      p2   = gf_mul(a, a);
      p3   = gf_mul(p2, a);
      p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
      p15  = gf_mul(p12, p3);
      p240 = gf_mul(p15, p15);
      p240 = gf_mul(p240, p240);
      p240 = gf_mul(p240, p240);
      p240 = gf_mul(p240, p240);
      p252 = gf_mul(p240, p12);
      return gf_mul(p252, p2);
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

endpackage

// File: rtl/aes_sbox_unit.sv
module aes_sbox_unit
   import aes_step_pkg::*;
#(
   parameter bit INVERSE = 1'b0
) (
   input  logic [7:0] din,
   output logic [7:0] dout
);
   localparam logic [7:0] FWD_C = 8'h63;
   localparam logic [7:0] INV_C = 8'h05;

   generate
      if (INVERSE) begin : g_inv
         logic [7:0] pre;
         always_comb begin
            pre  = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ INV_C;
            dout = gf_inv(pre);
         end
      end else begin : g_fwd
         logic [7:0] iv;
         always_comb begin
            iv   = gf_inv(din);
            dout = iv ^ rotl8(iv, 1) ^ rotl8(iv, 2) ^ rotl8(iv, 3)
                   ^ rotl8(iv, 4) ^ FWD_C;
         end
      end
   endgenerate
endmodule

// File: rtl/aes_col_expand.sv
module aes_col_expand
   import aes_step_pkg::*;
#(
   parameter bit INVERSE = 1'b0,
   parameter int NBYTES  = 4
) (
   input  logic [7:0]          s,
   output logic [8*NBYTES-1:0] word
);
   localparam logic [31:0] COEF = INVERSE ? 32'h0B0D090E : 32'h03010102;

   if (NBYTES != 4) begin : g_bad_nbytes
      $error("aes_col_expand: column must be four bytes");
   end

   genvar g;
   generate
      for (g = 0; g < NBYTES; g++) begin : g_lane
         assign word[8*g +: 8] = gf_mul(s, COEF[8*g +: 8]);
      end
   endgenerate
endmodule

// File: rtl/aes_byte_step.sv
module aes_byte_step
   import aes_step_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        opcode,
   input  logic [1:0]        bsel,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int SEL_W  = $clog2(NBYTES);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("aes_byte_step: BYTE_W must be 8");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("aes_byte_step: DATA_W must be 32");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("aes_byte_step: byte index must be two bits");
   end

   aes_op_e    op;
   logic [7:0] pick;
   logic [7:0] s_fwd;
   logic [7:0] s_inv;
   logic [DATA_W-1:0] col_fwd;
   logic [DATA_W-1:0] col_inv;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] rot;
   logic [DATA_W-1:0] nxt;

   assign op   = aes_op_e'(opcode);
   assign pick = op_b[{bsel, 3'b000} +: 8];

   aes_sbox_unit #(.INVERSE(1'b0)) u_sb_fwd (.din(pick), .dout(s_fwd));
   aes_sbox_unit #(.INVERSE(1'b1)) u_sb_inv (.din(pick), .dout(s_inv));

   aes_col_expand #(.INVERSE(1'b0), .NBYTES(NBYTES)) u_col_fwd (.s(s_fwd), .word(col_fwd));
   aes_col_expand #(.INVERSE(1'b1), .NBYTES(NBYTES)) u_col_inv (.s(s_inv), .word(col_inv));

   always_comb begin
      unique case (op)
         OP_ENC_LAST: word = {{(DATA_W-8){1'b0}}, s_fwd};
         OP_ENC_MID:  word = col_fwd;
         OP_DEC_LAST: word = {{(DATA_W-8){1'b0}}, s_inv};
         OP_DEC_MID:  word = col_inv;
         default:     word = '0;
      endcase
   end

   // byte rotation left by bsel lanes
   genvar j;
   generate
      for (j = 0; j < NBYTES; j++) begin : g_rot
         logic [SEL_W-1:0] src;
         assign src = SEL_W'(j) - bsel;
         assign rot[8*j +: 8] = word[{src, 3'b000} +: 8];
      end
   endgenerate

   assign nxt = rot ^ op_a;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               result    <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) result <= nxt;
            end
         end
      end else begin : g_comb
         assign out_valid = rst_n & in_valid;
         assign result    = rst_n ? nxt : '0;
      end
   endgenerate
endmodule

// File: rtl/aes_byte_step_chk.sv
module aes_byte_step_chk #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        opcode,
   input logic [1:0]        bsel,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   function automatic logic [31:0] rotr_bytes(input logic [31:0] w, input logic [1:0] n);
      logic [63:0] d;
      d = {w, w} >> (8 * n);
      return d[31:0];
   endfunction

   logic [31:0] diff_back;
   logic [1:0]  bsel_q;
   logic [31:0] op_a_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bsel_q <= '0;
         op_a_q <= '0;
      end else begin
         bsel_q <= bsel;
         op_a_q <= op_a;
      end
   end
   assign diff_back = rotr_bytes(result ^ op_a_q, bsel_q);

   generate
      if (OUT_REG) begin : g_props
         assert_reset_clear_R1: assert property (@(posedge clk)
            !rst_n |=> (out_valid == 1'b0 && result == '0));

         assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

         assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

         assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));

         assert_final_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !opcode[0]) |=> (diff_back[31:8] == 24'h0));

         assert_mix_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == 2'b01) |=>
               (diff_back[23:16] == diff_back[15:8]
                && diff_back[31:24] == (diff_back[23:16] ^ diff_back[7:0])));
      end
   endgenerate
endmodule

bind aes_byte_step aes_byte_step_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/aes_byte_step_tb.sv
module aes_byte_step_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  opcode = 2'b00;
   logic [1:0]  bsel = 2'b00;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        out_valid;
   logic [31:0] result;

   int total = 0;
   int bad = 0;

   logic [7:0] sb [256];
   logic [7:0] isb [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   aes_byte_step u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .bsel(bsel), .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
   );

   function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      logic [7:0] y = b;
      while (y != 0) begin
         if (y[0]) p ^= x;
         x = (x << 1) ^ ((x & 8'h80) != 0 ? 8'h1b : 8'h00);
         y = y >> 1;
      end
      return p;
   endfunction

   function automatic logic [7:0] rl(input logic [7:0] v, input int n);
      return (v << n) | (v >> (8 - n));
   endfunction

   function automatic logic [31:0] expect_val(input logic [1:0] opc, input logic [1:0] bs,
                                              input logic [31:0] a, input logic [31:0] b);
      logic [7:0]  x;
      logic [7:0]  s;
      logic [31:0] w;
      logic [63:0] d;
      x = 8'((b >> (8 * bs)) & 32'hff);
      s = opc[1] ? isb[x] : sb[x];
      case (opc)
         2'b00, 2'b10: w = {24'h0, s};
         2'b01: w = {rmul(s, 8'h03), s, s, rmul(s, 8'h02)};
         default: w = {rmul(s, 8'h0b), rmul(s, 8'h0d), rmul(s, 8'h09), rmul(s, 8'h0e)};
      endcase
      d = {w, w} << (8 * bs);
      return d[63:32] ^ a;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
      end
   endtask

   task automatic build_tables();
      logic [7:0] p = 8'h01;
      logic [7:0] q = 8'h01;
      logic [7:0] x;
      do begin
         p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00);
         q = q ^ (q << 1);
         q = q ^ (q << 2);
         q = q ^ (q << 4);
         if (q[7]) q = q ^ 8'h09;
         x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
         sb[p] = x ^ 8'h63;
      end while (p != 8'h01);
      sb[0] = 8'h63;
      for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
   endtask

   // one isolated operation: apply at a falling edge, compare one falling edge later
   task automatic run_one(input string tag, input logic [1:0] opc, input logic [1:0] bs,
                          input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      in_valid = 1'b1; opcode = opc; bsel = bs; op_a = a; op_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, result, expect_val(opc, bs, a, b));
      check({tag, " valid R8"}, {31'h0, out_valid}, 32'h1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
      check("R1 result in reset", result, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
   endtask

   task automatic t_known();
      run_one("R3 sbox(00)", 2'b00, 2'b00, 32'h0, 32'h0000_0000);
      check("R3 literal 63", result, 32'h0000_0063);
      run_one("R3 sbox(53)", 2'b00, 2'b00, 32'h0, 32'h0000_0053);
      check("R3 literal ed", result, 32'h0000_00ed);
      run_one("R5 isbox(63)", 2'b10, 2'b00, 32'h0, 32'h0000_0063);
      check("R5 literal 00", result, 32'h0000_0000);
      run_one("R4 mix of 01->7c", 2'b01, 2'b00, 32'h0, 32'h0000_0001);
      check("R4 literal", result, 32'h847c_7cf8);
   endtask

   task automatic t_sweep(input logic [1:0] opc, input string tag);
      for (int v = 0; v < 256; v++) begin
         for (int bs = 0; bs < 4; bs++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            b = (b & ~(32'hff << (8 * bs))) | (32'(v) << (8 * bs));
            run_one(tag, opc, 2'(bs), a, b);
         end
      end
   endtask

   task automatic t_other_bytes();
      for (int bs = 0; bs < 4; bs++) begin
         logic [31:0] r0;
         run_one("R2 base", 2'b01, 2'(bs), 32'h1234_5678, 32'h5555_5555);
         r0 = result;
         run_one("R2 alt", 2'b01, 2'(bs),
                 32'h1234_5678, (32'haaaa_aaaa & ~(32'hff << (8*bs))) | (32'h55 << (8*bs)));
         check("R2 unselected bytes ignored", result, r0);
      end
   endtask

   task automatic t_rotation();
      for (int bs = 0; bs < 4; bs++) begin
         run_one("R7 rotate", 2'b00, 2'(bs), 32'h0, 32'h0101_0101);
         check("R7 lane position", result, 32'h7c << (8 * bs));
      end
   endtask

   task automatic t_back_to_back();
      logic [31:0] ea;
      logic [1:0]  po;
      logic [1:0]  pb;
      logic [31:0] pa;
      logic [31:0] pbv;
      @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         if (k > 0) begin
            check("R8 back-to-back result", result, expect_val(po, pb, pa, pbv));
            check("R8 back-to-back valid", {31'h0, out_valid}, 32'h1);
         end
         po = 2'(k); pb = 2'(k >> 2); pa = $urandom; pbv = $urandom;
         in_valid = 1'b1; opcode = po; bsel = pb; op_a = pa; op_b = pbv;
         @(negedge clk);
      end
      in_valid = 1'b0;
      ea = expect_val(po, pb, pa, pbv);
      check("R8 last of burst", result, ea);
      @(negedge clk);
      check("R8 valid drops", {31'h0, out_valid}, 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] keep;
      run_one("R9 setup", 2'b11, 2'b10, 32'hdead_beef, 32'h00c3_0000);
      keep = result;
      for (int k = 0; k < 4; k++) begin
         opcode = 2'(k); bsel = 2'(3 - k); op_a = $urandom; op_b = $urandom;
         @(negedge clk);
         check("R9 result held", result, keep);
         check("R9 no valid while idle", {31'h0, out_valid}, 32'h0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      build_tables();
      t_reset();
      t_known();
      t_sweep(2'b00, "R3 enc final");
      t_sweep(2'b01, "R4 enc middle");
      t_sweep(2'b10, "R5 dec final");
      t_sweep(2'b11, "R6 dec middle");
      t_other_bytes();
      t_rotation();
      t_back_to_back();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule